// File: doc/BRIEF.md
# Device interrupt pin route table

This block holds the table that decides which of eight shared interrupt request lines (index 0 to 7) each PCI device slot's four interrupt pins, INTA to INTD, drive. Slots 25 to 31 each own a 16-bit route word. The word has one 4-bit field per pin, and the low three bits of each field are the line index. One of these slots, slot 30, is hardwired: it always routes its pins to lines 4 to 7 and cannot be written. All other slots have no storage. They follow a rotating rule that keeps them on lines 4 to 7.

Software reaches the route words through a 16-byte little-endian window. Each access uses a simple strobe interface with a 32-bit data path and four byte enables. The access address is reduced to the window size. Any byte lane that would fall past the last window byte is dropped rather than wrapped. Every write strobe raises a one-cycle change pulse, so interrupt routing users know to refresh. A combinational lookup port turns a slot number and a pin into the line index.

Top module: `irq_route_table`

## Requirements
- R1: After synchronous reset every writable route word reads 0x3210, so pin n of slots 25 to 29 and 31 maps to line n. The read data register and the change pulse are zero.
- R2: The route word of slot s (25 to 31) sits at window byte offset 2*(s-25), low byte first. Read lane i returns window byte (offset+i) in data bits [8i+7:8i].
- R3: A write stores exactly the window bytes whose lane enable is set. Without a write strobe, no stored byte changes.
- R4: Slot 30's word always reads 0x7654 and ignores writes. Its pin n always looks up to line 4+n.
- R5: A slot outside 25 to 31 looks up pin p to line ((slot+p) mod 4)+4.
- R6: For slots 25 to 29 and 31, pin n looks up to bits [4n+2:4n] of the slot's word. Bit 4n+3 is stored and read back but does not affect the lookup.
- R7: Only the low four address bits select the window byte. Higher address bits are ignored.
- R8: A lane whose byte position (masked address + lane) is 16 or more is dropped. It writes nothing (no wrap to byte 0) and reads as zero.
- R9: Window bytes 14 and 15 hold nothing. They read as zero and writes to them have no effect.
- R10: The change pulse is high for exactly the one cycle after each cycle with a write strobe, including writes that store nothing. It is low otherwise.
- R11: The lookup port is combinational and shows a written route from the clock edge that stores it.
- R12: A read strobe loads the read data register at the clock edge. Lanes whose enable is clear return zero. Without a read strobe the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W (8) | Byte address of lane 0 of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| byte_en | input | 4 | Lane enables |
| wr_data | input | 32 | Write data, lane i in bits [8i+7:8i] |
| rd_data | output | 32 | Registered read data |
| route_chg | output | 1 | One-cycle pulse after each write |
| lk_slot | input | 5 | Slot number to look up |
| lk_pin | input | 2 | Pin to look up, 0 = INTA to 3 = INTD |
| lk_pirq | output | 3 | Line index for that slot and pin |

## Verification
The bench uses the default parameters: 32 slots, routed slots starting at 25, the fixed slot at 30 and an 8-bit address over a 16-byte window. With these values, ordinary 4-lane accesses at masked offsets 13 to 15 run off the end of the window. Random upper address bits exercise the masking, and a full sweep of all 128 slot and pin pairs covers the hardwired slot, the writable slots and the rotating rule after each phase of random traffic.

// File: rtl/rtr_pkg.sv
// Shared constants and helpers for the interrupt route table.
// Assumes STRIDE*NUM_PINS equals the route word width.
package rtr_pkg;
    localparam int SLOT_W       = 5;
    localparam int PIN_W        = 2;
    localparam int PIRQ_W       = 3;
    localparam int NUM_PINS     = 4;
    localparam int STRIDE       = 4;
    localparam int REG_W        = STRIDE * NUM_PINS;
    localparam int REG_BYTES    = REG_W / 8;
    localparam int FIRST_ROUTED = 25;
    localparam int NUM_ROUTED   = 7;
    localparam int FIXED_SLOT   = 30;
    localparam int SHARED_BASE  = 4;
    localparam int WIN_AW       = 4;
    localparam int WIN_BYTES    = 1 << WIN_AW;
    localparam int LANES        = 4;
    localparam int DATA_W       = LANES * 8;

    // Build a route word: identity for writable slots, upper lines for the fixed slot.
    function automatic logic [REG_W-1:0] route_default(input bit hardwired);
        logic [REG_W-1:0] v;
        v = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            v[n*STRIDE +: PIRQ_W] = hardwired ? PIRQ_W'(SHARED_BASE + n) : PIRQ_W'(n);
        end
        return v;
    endfunction
endpackage

// File: rtl/rtr_regfile.sv
// Route word storage. Presents the whole window as a flat byte image.
// Assumes the window holds at least NUM_ROUTED*REG_BYTES bytes; spare bytes read zero.
// Writable bytes reset to the identity route; the hardwired slot is a constant.
module rtr_regfile
    import rtr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WIN_AW-1:0]       win_base,
    input  logic [LANES-1:0]        byte_en,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [WIN_BYTES*8-1:0]  win_image
);
    localparam logic [REG_W-1:0] RW_DEFAULT  = route_default(1'b0);
    localparam logic [REG_W-1:0] FIX_DEFAULT = route_default(1'b1);
    localparam int USED_BYTES = NUM_ROUTED * REG_BYTES;

    generate
        for (genvar r = 0; r < NUM_ROUTED; r++) begin : g_reg
            localparam int SLOT = FIRST_ROUTED + r;
            localparam int OFF  = r * REG_BYTES;
            if (SLOT == FIXED_SLOT) begin : g_fixed
                assign win_image[OFF*8 +: REG_W] = FIX_DEFAULT;
            end else begin : g_rw
                for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
                    logic [7:0] q_b;
                    logic       hit;
                    logic [7:0] nxt;
                    // Find the enabled lane, if any, that lands on this byte.
                    always_comb begin
                        hit = 1'b0;
                        nxt = q_b;
                        for (int l = 0; l < LANES; l++) begin
                            if (wr_en && byte_en[l] && (int'(win_base) + l == OFF + b)) begin
                                hit = 1'b1;
                                nxt = wr_data[l*8 +: 8];
                            end
                        end
                    end
                    // Hold the byte; load reset default or written data.
                    always_ff @(posedge clk) begin
                        if (!rst_n)   q_b <= RW_DEFAULT[b*8 +: 8];
                        else if (hit) q_b <= nxt;
                    end
                    assign win_image[(OFF+b)*8 +: 8] = q_b;
                end
            end
        end
        for (genvar s = USED_BYTES; s < WIN_BYTES; s++) begin : g_spare
            assign win_image[s*8 +: 8] = 8'h00;
        end
    endgenerate

    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(win_image)); // R3
    AST_FIXED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (win_image[(FIXED_SLOT-FIRST_ROUTED)*REG_BYTES*8 +: REG_W] == 16'h7654)); // R4
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (win_image[WIN_BYTES*8-1 -: 16] == 16'h0000)); // R9
endmodule

// File: rtl/rtr_readmux.sv
// Read path: gathers enabled lanes from the window image into a data register.
// Lanes past the window end or with a clear enable return zero.
module rtr_readmux
    import rtr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [WIN_AW-1:0]       win_base,
    input  logic [LANES-1:0]        byte_en,
    input  logic [WIN_BYTES*8-1:0]  win_image,
    output logic [DATA_W-1:0]       rd_data
);
    logic [DATA_W-1:0] rd_next;

    // Assemble each lane from its window byte, clipping at the window end.
    always_comb begin
        rd_next = '0;
        for (int l = 0; l < LANES; l++) begin
            if (byte_en[l] && (int'(win_base) + l < WIN_BYTES)) begin
                rd_next[l*8 +: 8] = win_image[(int'(win_base) + l)*8 +: 8];
            end
        end
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R12
    AST_RD_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && win_base == WIN_AW'(WIN_BYTES-1)) |=> (rd_data[DATA_W-1:8] == '0)); // R8
endmodule

// File: rtl/rtr_lookup.sv
// Combinational slot/pin to line lookup from the window image.
// Slots with a route word decode its field; others use the rotating upper-line rule.
// Clock and reset serve only the local checks.
module rtr_lookup
    import rtr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIN_BYTES*8-1:0]  win_image,
    input  logic [SLOT_W-1:0]       lk_slot,
    input  logic [PIN_W-1:0]        lk_pin,
    output logic [PIRQ_W-1:0]       lk_pirq
);
    int              slot_i;
    int              pin_i;
    logic [REG_W-1:0] word;

    // Pick the route word or the rotating rule for the requested slot.
    always_comb begin
        slot_i = int'(lk_slot);
        pin_i  = int'(lk_pin);
        word   = '0;
        if (slot_i >= FIRST_ROUTED && slot_i < FIRST_ROUTED + NUM_ROUTED) begin
            word    = win_image[(slot_i - FIRST_ROUTED)*REG_W +: REG_W];
            lk_pirq = word[pin_i*STRIDE +: PIRQ_W];
        end else begin
            lk_pirq = PIRQ_W'(((slot_i + pin_i) % NUM_PINS) + SHARED_BASE);
        end
    end

    AST_UNROUTED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_slot) < FIRST_ROUTED) |-> (lk_pirq >= PIRQ_W'(SHARED_BASE))); // R5
    AST_FIXED_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_slot) == FIXED_SLOT) |-> (lk_pirq == PIRQ_W'(SHARED_BASE) + PIRQ_W'(lk_pin))); // R4
endmodule

// File: rtl/irq_route_table.sv
// Top of the device interrupt pin route table.
// Masks the access address to the window, drives storage, read path and lookup,
// and emits a one-cycle change pulse after every write strobe.
// Assumes ADDR_W is larger than the window address width.
module irq_route_table
    import rtr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [LANES-1:0]    byte_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic                route_chg,
    input  logic [SLOT_W-1:0]   lk_slot,
    input  logic [PIN_W-1:0]    lk_pin,
    output logic [PIRQ_W-1:0]   lk_pirq
);
    logic [WIN_AW-1:0]      win_base;
    logic [WIN_BYTES*8-1:0] win_image;
    logic                   unused_addr_hi;

    assign win_base       = acc_addr[WIN_AW-1:0];
    assign unused_addr_hi = ^acc_addr[ADDR_W-1:WIN_AW];

    rtr_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .win_base(win_base),
        .byte_en(byte_en), .wr_data(wr_data), .win_image(win_image)
    );

    rtr_readmux u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .win_base(win_base),
        .byte_en(byte_en), .win_image(win_image), .rd_data(rd_data)
    );

    rtr_lookup u_lk (
        .clk(clk), .rst_n(rst_n), .win_image(win_image),
        .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
    );

    // Flag a routing change in the cycle after each write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) route_chg <= 1'b0;
        else        route_chg <= wr_en;
    end

    AST_CHG_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> route_chg); // R10
    AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        route_chg |-> $past(wr_en)); // R10
endmodule

// File: tb/sim_irq_route_table.sv
module sim_irq_route_table;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  byte_en = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        route_chg;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_table u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_data), .route_chg(route_chg),
        .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit writable(input int p);
        return (p < 14) && (p != 10) && (p != 11);
    endfunction

    function automatic logic [2:0] exp_pirq(input int slot, input int pin);
        logic [15:0] w;
        if (slot >= 25 && slot <= 31) begin
            w = {mdl[2*(slot-25)+1], mdl[2*(slot-25)]};
            return w[pin*4 +: 3];
        end
        return 3'(((slot + pin) % 4) + 4);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] addr, input logic [3:0] be);
        logic [31:0] v;
        int b;
        v = '0;
        b = int'(addr[3:0]);
        for (int l = 0; l < 4; l++) begin
            if (be[l] && b + l < 16) v[l*8 +: 8] = mdl[b + l];
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        for (int s = 0; s < 7; s++) begin
            mdl[2*s]   = (s == 5) ? 8'h54 : 8'h10;
            mdl[2*s+1] = (s == 5) ? 8'h76 : 8'h32;
        end
    endtask

    // R10 checked on every write; model follows R3, R4, R7, R8, R9.
    task automatic do_wr(input logic [7:0] addr, input logic [3:0] be, input logic [31:0] d);
        int b;
        @(negedge clk);
        acc_addr = addr; byte_en = be; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 pulse after write", {31'd0, route_chg}, 32'd1);
        b = int'(addr[3:0]);
        for (int l = 0; l < 4; l++) begin
            if (be[l] && b + l < 16 && writable(b + l)) mdl[b + l] = d[l*8 +: 8];
        end
    endtask

    task automatic do_rd(input string req, input logic [7:0] addr, input logic [3:0] be);
        @(negedge clk);
        acc_addr = addr; byte_en = be; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, exp_rd(addr, be));
        check("R10 no pulse without write", {31'd0, route_chg}, 32'd0);
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                lk_slot = 5'(s); lk_pin = 2'(p);
                #1;
                check(req, {29'd0, lk_pirq}, {29'd0, exp_pirq(s, p)});
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        logic [7:0]  a;
        seed_v = $urandom(32'd20240611);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_data reset", rd_data, 32'd0);
        check("R1 route_chg reset", {31'd0, route_chg}, 32'd0);
        do_rd("R1 R2 reset words 0..3", 8'h00, 4'hF);
        check("R1 literal", rd_data, 32'h3210_3210);
        do_rd("R1 R4 reset words 8..11", 8'h08, 4'hF);
        check("R4 literal fixed word", rd_data, 32'h7654_3210);
        do_rd("R1 R9 reset words 12..15", 8'h0C, 4'hF);
        check("R9 literal spare", rd_data, 32'h0000_3210);
        sweep("R1 R5 reset lookup");

        // R3: single enabled byte
        do_wr(8'h00, 4'b0100, 32'hFF5A_EEDD);
        do_rd("R3 byte enable write", 8'h00, 4'hF);
        check("R3 literal", rd_data, 32'h325A_3210);

        // R6 and R11: upper field bit ignored, lookup immediate
        do_wr(8'h00, 4'b0011, 32'h0000_FEDC);
        for (int p = 0; p < 4; p++) begin
            lk_slot = 5'd25; lk_pin = 2'(p);
            #1;
            check("R6 R11 field decode", {29'd0, lk_pirq}, {29'd0, 3'(p + 4)});
        end
        do_rd("R6 stored bit 3 read back", 8'h00, 4'b0011);

        // R4: writes to hardwired slot ignored
        do_wr(8'h08, 4'hF, 32'h0000_0000);
        do_rd("R4 fixed word unchanged", 8'h08, 4'hF);
        check("R4 literal after write", rd_data, 32'h7654_0000);
        lk_slot = 5'd30; lk_pin = 2'd2; #1;
        check("R4 fixed lookup", {29'd0, lk_pirq}, 32'd6);

        // R7: high address bits ignored
        do_wr(8'hF4, 4'hF, 32'h0123_4567);
        do_rd("R7 masked address", 8'h04, 4'hF);

        // R8: clip at window end, no wrap
        do_wr(8'h0D, 4'hF, 32'hAABB_CCDD);
        do_rd("R8 clipped write", 8'h0C, 4'hF);
        check("R8 literal", rd_data, 32'h0000_DD10);
        do_rd("R8 no wrap to byte 0", 8'h00, 4'hF);
        do_rd("R8 clipped read", 8'h0F, 4'hF);
        check("R8 literal read", rd_data, 32'h0000_0000);

        // R9: spare bytes
        do_wr(8'h0E, 4'b0011, 32'h0000_9999);
        do_rd("R9 spare bytes stay zero", 8'h0C, 4'hF);

        // R12: disabled read lanes are zero
        do_rd("R12 read lane enables", 8'h02, 4'b0101);
        sweep("R5 R6 R11 lookup after directed");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            a = 8'($urandom);
            if ($urandom % 2 == 0) do_wr(a, 4'($urandom), $urandom);
            else do_rd("R2 R3 R8 R12 random read", a, 4'($urandom));
            if (i % 100 == 99) sweep("R5 R6 R11 random lookup");
        end
        finish_run();
    end
endmodule